// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns a flat physical byte address into the multiplexed address that SIMM-style DRAM expects. It also drives one active-low row strobe for each bank and a shared active-low column strobe. The row/column split is chosen at request time by a geometry input. The choices are 11 row bits with 11 column bits, or 12 row bits with 10 column bits.

Each bank owns a fixed 32-Mbyte segment of the address space. Bank N therefore starts at N × 32 Mbytes, whatever is fitted in it. A population table, which software writes after reset, records how much memory each bank holds. When a request lands in an empty bank, or past the filled part of a partly populated bank, the block raises a one-cycle error and asserts no strobe.

Accepted requests run a fixed sequence through four states:

- IDLE: waiting for a request.
- ROW: the row address is presented with the bank's row strobe low.
- COL: the column address is presented with the column strobe also low.
- PRE: precharge, with every strobe high.

The block then returns to IDLE. The transitions are:

- IDLE→ROW on an accepted, valid request.
- IDLE→IDLE on a rejected request, which raises the error.
- ROW→COL, COL→PRE and PRE→IDLE, each when that phase's cycle count runs out.

Top module: `dram_addr_mux`

## Requirements
- R1: After reset, all row strobes and the column strobe are high, `err` and `busy` are low, and every bank reads as unpopulated. A request made before any configuration write is therefore rejected with `err`.
- R2: The bank is byte address bits [26:25]. Only that bank's bit of `ras_n` goes low during an access, and no more than one bit is ever low.
- R3: With `geom_12x10`=0, the row address is byte address bits [24:14] and the column address is bits [13:3]. Both are zero-extended onto the 12-bit `ma`.
- R4: With `geom_12x10`=1, the row address is bits [24:13] and the column address is bits [12:3], zero-extended onto `ma`.
- R5: A request accepted at a clock edge in IDLE gives T_ROW cycles of ROW, starting in the cycle after that edge. During ROW, `ma` carries the row address, the bank's row strobe is low and `cas_n` is high.
- R6: ROW is followed by T_COL cycles of COL. During COL, `ma` carries the column address, and both the row strobe and `cas_n` are low.
- R7: COL is followed by T_PRE cycles of PRE with every strobe high. After PRE the block is back in IDLE. `busy` is high exactly during ROW, COL and PRE.
- R8: The bank size codes are 00 = none, 01 = 8 Mbytes, 10 = 32 Mbytes and 11 = none. A request to a bank coded none is rejected. In the cycle after the accepting edge `err` is high for exactly one cycle, no strobe goes low and `busy` stays low.
- R9: In an 8-Mbyte bank, an offset within the segment (bits [24:0]) of 0x800000 or more is rejected as in R8. The top valid word is still accepted.
- R10: A request raised while `busy` is high is ignored. The running access continues unchanged and no second access follows it.
- R11: A write with `cfg_we` high stores `cfg_size` for bank `cfg_bank` at that edge, and it governs every later request. The geometry is sampled at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Population table write strobe |
| cfg_bank | input | 2 | Bank index to write |
| cfg_size | input | 2 | Size code for that bank |
| geom_12x10 | input | 1 | 0: 11x11 split, 1: 12x10 split |
| req_valid | input | 1 | Access request |
| req_addr | input | 27 | Byte address of the request |
| busy | output | 1 | Access sequence in progress |
| err | output | 1 | One-cycle pulse for a request to unpopulated memory |
| ras_n | output | 4 | Per-bank row strobes, active low |
| cas_n | output | 1 | Column strobe, active low |
| ma | output | 12 | Multiplexed DRAM address |

## Verification
Addresses with distinct bit patterns in the row and column fields are used in both geometries. A wrong split point or a wrong byte offset then shows up as a different value on `ma`. Accesses go to the lowest and highest banks and to the last valid word of an 8-Mbyte bank. This separates the bank decode from the size check on both sides of the 8-Mbyte limit. Each size code is written in turn, including the reserved one, to show how the population table rules accept or reject a request. A request held high through a whole access tells ignoring it apart from queuing it.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_PRE  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_8M   = 2'b01,
        SZ_32M  = 2'b10,
        SZ_RSVD = 2'b11
    } bank_size_t;
endpackage

// File: rtl/dram_bank_decode.sv
module dram_bank_decode
    import dram_mux_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int SEG_BITS   = 25,
    parameter int SMALL_BITS = 23,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [BANK_W-1:0]        cfg_bank,
    input  logic [1:0]               cfg_size,
    input  logic [BANK_W-1:0]        bank,
    input  logic [SEG_BITS-1:SMALL_BITS] off_hi,
    output logic                     hit
);
    bank_size_t pop [NUM_BANKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BANKS; i++) pop[i] <= SZ_NONE;
        end else if (cfg_we) begin
            pop[cfg_bank] <= bank_size_t'(cfg_size);
        end
    end

    always_comb begin
        unique case (pop[bank])
            SZ_32M:  hit = 1'b1;
            SZ_8M:   hit = (off_hi == '0);
            default: hit = 1'b0;
        endcase
    end

    AST_POP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> pop[$past(cfg_bank)] == bank_size_t'($past(cfg_size))); // R11
endmodule

// File: rtl/dram_rc_split.sv
module dram_rc_split #(
    parameter int WORD_BITS = 22,
    parameter int MA_W      = 12,
    localparam int COL_WIDE = WORD_BITS / 2,
    localparam int COL_NARW = COL_WIDE - 1
) (
    input  logic [WORD_BITS-1:0] word,
    input  logic                 geom_12x10,
    output logic [MA_W-1:0]      row,
    output logic [MA_W-1:0]      col
);
    logic [WORD_BITS-1:0] row_wide, row_narw;

    assign row_wide = word >> COL_WIDE;
    assign row_narw = word >> COL_NARW;

    always_comb begin
        row = '0;
        col = '0;
        if (geom_12x10) begin
            row = row_narw[MA_W-1:0];
            col[COL_NARW-1:0] = word[COL_NARW-1:0];
        end else begin
            row = row_wide[MA_W-1:0];
            col[COL_WIDE-1:0] = word[COL_WIDE-1:0];
        end
    end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_mux_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int MA_W      = 12,
    parameter int T_ROW     = 2,
    parameter int T_COL     = 2,
    parameter int T_PRE     = 1,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int T_MAX    = (T_ROW > T_COL) ? ((T_ROW > T_PRE) ? T_ROW : T_PRE)
                                              : ((T_COL > T_PRE) ? T_COL : T_PRE),
    localparam int CNT_W    = $clog2(T_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 ok,
    input  logic [BANK_W-1:0]    bank,
    input  logic [MA_W-1:0]      row,
    input  logic [MA_W-1:0]      col,
    output logic                 busy,
    output logic                 err,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic                 cas_n,
    output logic [MA_W-1:0]      ma
);
    seq_state_t          state;
    logic [CNT_W-1:0]    cnt;
    logic [BANK_W-1:0]   bank_q;
    logic [MA_W-1:0]     row_q, col_q;
    logic                err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    if (ok) begin
                        state  <= ST_ROW;
                        cnt    <= CNT_W'(T_ROW - 1);
                        bank_q <= bank;
                        row_q  <= row;
                        col_q  <= col;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                ST_ROW: if (cnt == '0) begin
                    state <= ST_COL;
                    cnt   <= CNT_W'(T_COL - 1);
                end else cnt <= cnt - 1'b1;
                ST_COL: if (cnt == '0) begin
                    state <= ST_PRE;
                    cnt   <= CNT_W'(T_PRE - 1);
                end else cnt <= cnt - 1'b1;
                ST_PRE: if (cnt == '0) begin
                    state <= ST_IDLE;
                end else cnt <= cnt - 1'b1;
            endcase
        end
    end

    always_comb begin
        ras_n = '1;
        cas_n = 1'b1;
        ma    = '0;
        busy  = (state != ST_IDLE);
        err   = err_q;
        unique case (state)
            ST_IDLE: ;
            ST_ROW: begin
                ras_n[bank_q] = 1'b0;
                ma            = row_q;
            end
            ST_COL: begin
                ras_n[bank_q] = 1'b0;
                cas_n         = 1'b0;
                ma            = col_q;
            end
            ST_PRE: ;
        endcase
    end

    AST_ONE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ras_n)); // R2
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (&ras_n && cas_n && !busy)); // R8
    AST_RAS_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> !(&$past(ras_n))); // R6
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> &ras_n); // R7
    AST_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW && $past(state) == ST_ROW) |-> $stable(ma)); // R5
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int SEG_BITS   = 25,
    parameter int SMALL_BITS = 23,
    parameter int OFF_BITS   = 3,
    parameter int MA_W       = 12,
    parameter int T_ROW      = 2,
    parameter int T_COL      = 2,
    parameter int T_PRE      = 1,
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int ADDR_W    = SEG_BITS + BANK_W,
    localparam int WORD_BITS = SEG_BITS - OFF_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [BANK_W-1:0]    cfg_bank,
    input  logic [1:0]           cfg_size,
    input  logic                 geom_12x10,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 busy,
    output logic                 err,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic                 cas_n,
    output logic [MA_W-1:0]      ma
);
    logic [BANK_W-1:0] bank;
    logic [MA_W-1:0]   row, col;
    logic              hit;

    assign bank = req_addr[ADDR_W-1:SEG_BITS];

    dram_bank_decode #(
        .NUM_BANKS(NUM_BANKS), .SEG_BITS(SEG_BITS), .SMALL_BITS(SMALL_BITS)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_size(cfg_size), .bank(bank),
        .off_hi(req_addr[SEG_BITS-1:SMALL_BITS]), .hit(hit)
    );

    dram_rc_split #(.WORD_BITS(WORD_BITS), .MA_W(MA_W)) u_split (
        .word(req_addr[SEG_BITS-1:OFF_BITS]), .geom_12x10(geom_12x10),
        .row(row), .col(col)
    );

    dram_seq #(
        .NUM_BANKS(NUM_BANKS), .MA_W(MA_W),
        .T_ROW(T_ROW), .T_COL(T_COL), .T_PRE(T_PRE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(req_valid), .ok(hit), .bank(bank),
        .row(row), .col(col), .busy(busy), .err(err), .ras_n(ras_n),
        .cas_n(cas_n), .ma(ma)
    );

    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !err); // R10
endmodule

// File: tb/dram_addr_mux_test.sv
module dram_addr_mux_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_ROW = 2, T_COL = 2, T_PRE = 1;

    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0, geom_12x10 = 0, req_valid = 0;
    logic [1:0]  cfg_bank = 0, cfg_size = 0;
    logic [26:0] req_addr = 0;
    logic        busy, err, cas_n;
    logic [3:0]  ras_n;
    logic [11:0] ma;
    int vectors = 0, miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_addr_mux uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_size(cfg_size), .geom_12x10(geom_12x10), .req_valid(req_valid),
        .req_addr(req_addr), .busy(busy), .err(err), .ras_n(ras_n),
        .cas_n(cas_n), .ma(ma)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [1:0] b, input logic [1:0] s);
        @(negedge clk);
        cfg_we = 1; cfg_bank = b; cfg_size = s;
        @(negedge clk);
        cfg_we = 0;
    endtask

    function automatic logic [11:0] exp_row(input logic [26:0] a, input logic g);
        return g ? {a[24:13]} : {1'b0, a[24:14]};
    endfunction
    function automatic logic [11:0] exp_col(input logic [26:0] a, input logic g);
        return g ? {2'b0, a[12:3]} : {1'b0, a[13:3]};
    endfunction

    // Full accepted access; optional hold of a second request through busy (R10)
    task automatic do_access(input string tag, input logic [26:0] a, input logic g,
                             input logic hold);
        logic [3:0] rexp;
        rexp = ~(4'b1 << a[26:25]);
        @(negedge clk);
        req_valid = 1; req_addr = a; geom_12x10 = g;
        @(negedge clk);
        if (hold) begin req_addr = a ^ 27'h2AAAAA8; geom_12x10 = ~g; end
        else req_valid = 0;
        for (int i = 0; i < T_ROW; i++) begin
            chk({tag, " R5 row ma"}, 32'(ma), 32'(exp_row(a, g)));
            chk({tag, " R2 row ras"}, 32'(ras_n), 32'(rexp));
            chk({tag, " R5 row cas"}, 32'(cas_n), 32'd1);
            chk({tag, " R7 busy"}, 32'(busy), 32'd1);
            @(negedge clk);
        end
        for (int i = 0; i < T_COL; i++) begin
            chk({tag, " R6 col ma"}, 32'(ma), 32'(exp_col(a, g)));
            chk({tag, " R6 col ras"}, 32'(ras_n), 32'(rexp));
            chk({tag, " R6 col cas"}, 32'(cas_n), 32'd0);
            @(negedge clk);
        end
        req_valid = 0;
        for (int i = 0; i < T_PRE; i++) begin
            chk({tag, " R7 pre strobes"}, 32'({ras_n, cas_n}), 32'h1F);
            chk({tag, " R7 pre busy"}, 32'(busy), 32'd1);
            @(negedge clk);
        end
        chk({tag, " R7 idle"}, 32'({busy, ras_n, cas_n}), 32'h1F);
        if (hold) begin
            @(negedge clk);
            chk({tag, " R10 no second access"}, 32'({busy, ras_n, cas_n}), 32'h1F);
        end
    endtask

    task automatic do_reject(input string tag, input logic [26:0] a);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " R8 err"}, 32'(err), 32'd1);
        chk({tag, " R8 no strobe"}, 32'({busy, ras_n, cas_n}), 32'h1F);
        @(negedge clk);
        chk({tag, " R8 err pulse"}, 32'(err), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset strobes", 32'({ras_n, cas_n}), 32'h1F);
        chk("R1 reset err/busy", 32'({err, busy}), 32'd0);
        do_reject("R1 unconfigured", 27'h0000040);
    endtask

    task automatic t_geometry();
        write_cfg(2'd0, 2'b10);
        write_cfg(2'd3, 2'b10);
        do_access("R3 11x11", 27'h1ABCDE8, 1'b0, 1'b0);
        do_access("R4 12x10", 27'h1ABCDE8, 1'b1, 1'b0);
        do_access("R3 bank3 top", 27'h7FFFFF8, 1'b0, 1'b0);
        do_access("R4 bank3 alt", 27'h6AAAAA8, 1'b1, 1'b0);
    endtask

    task automatic t_small_bank();
        write_cfg(2'd1, 2'b01);
        do_access("R9 8M last word", 27'h27FFFF8, 1'b0, 1'b0);
        do_reject("R9 8M beyond", 27'h2800000);
        do_reject("R9 8M top of seg", 27'h3FFFFF8);
    endtask

    task automatic t_codes();
        do_reject("R8 bank2 none", 27'h4000100);
        write_cfg(2'd2, 2'b11);
        do_reject("R8 reserved code", 27'h4000100);
        write_cfg(2'd2, 2'b01);
        do_access("R11 after write", 27'h4000100, 1'b1, 1'b0);
        write_cfg(2'd2, 2'b00);
        do_reject("R11 cleared", 27'h4000100);
    endtask

    task automatic t_busy();
        do_access("R10 held req", 27'h0123458, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_geometry();
        t_small_bank();
        t_codes();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule